// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table with 1 KB pages. The logical address has three fields. From the most significant end they are a 12-bit upper index, a 10-bit lower index and a 10-bit byte offset. The upper index selects a word in the root table, which starts at `root_base_i`. That word gives the base of a second-level table. The lower index then selects a word in that second-level table, and that word holds the frame base. The physical address is the frame base joined to the untouched byte offset.

Each table word is 32 bits wide. Bit 0 is the present bit. Bits 31:10 are the base, and the block treats bits 9:0 of the base as zero. The block issues both reads, one after the other, through a single memory port. It holds `mem_req_o` and `mem_addr_o` steady until the memory answers with `mem_rvalid_i`. When the walk ends, `done_o` pulses for one cycle. At the same time `fault_o` shows whether either word lacked its present bit.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and after it is released, `mem_req_o`, `done_o`, `fault_o` and `paddr_o` are all zero.
- R2: When `start_i` is seen while the block is idle, `mem_req_o` rises on the next cycle. At the same time `mem_addr_o` becomes `root_base_i + 4*vaddr_i[31:20]`.
- R3: When the first read returns with bit 0 set, `mem_req_o` stays high on the next cycle. `mem_addr_o` becomes `{rdata[31:10],10'b0} + 4*va[19:10]`.
- R4: When the second read returns with bit 0 set, the next cycle shows `done_o`=1, `fault_o`=0, `mem_req_o`=0 and `paddr_o = {rdata[31:10], va[9:0]}`.
- R5: When the first read returns with bit 0 clear, the next cycle shows `done_o`=1 and `fault_o`=1. No second read is issued.
- R6: When the second read returns with bit 0 clear, the next cycle shows `done_o`=1 and `fault_o`=1. `paddr_o` is zero whenever `fault_o` is 1.
- R7: While a read waits for its response, `mem_req_o` stays high and `mem_addr_o` stays constant, for any number of wait cycles.
- R8: Any `start_i` or `vaddr_i` change while a walk is in progress is ignored. The result is that of the address captured at the start.
- R9: `done_o` is high for exactly one cycle. `paddr_o` and `fault_o` hold their values until the next walk completes.
- R10: A `mem_rvalid_i` pulse while no read is outstanding has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk for `vaddr_i` |
| vaddr_i | input | 32 | Logical address to translate |
| root_base_i | input | 32 | Byte address of the root table |
| paddr_o | output | 32 | Translated physical address |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk hit a word with the present bit clear |
| mem_req_o | output | 1 | Read request outstanding |
| mem_addr_o | output | 32 | Byte address of the table word being read |
| mem_rvalid_i | input | 1 | Read data valid; completes the outstanding read |
| mem_rdata_i | input | 32 | Table word read from memory |

## Verification
The properties assume the memory raises `mem_rvalid_i` only when it actually answers. They also assume that, during a response cycle, bit 0 of `mem_rdata_i` is the present bit of the word being returned.

The bench acts as the memory inside its walk task. It answers each request after a chosen delay of zero to three cycles and never returns data that was not requested. Outside those response cycles it drives `mem_rvalid_i` high only in the one deliberate idle-pulse test.

The table contents are computed arithmetically from the indices. The sweep mixes absent entries at both levels, stray bits in 9:1 of each word, and restart attempts made during a walk.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW        = 32,
  parameter int HI_W      = 12,
  parameter int MID_W     = 10,
  parameter int OFS_W     = 10,
  parameter int ENT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] root_base_i,
  output logic [AW-1:0] paddr_o,
  output logic          done_o,
  output logic          fault_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [AW-1:0] mem_rdata_i
);

  localparam int ENT_SH = $clog2(ENT_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_TOP, ST_LEAF} walk_st_e;

  walk_st_e       state_q;
  logic [AW-1:0]  va_q;
  logic [AW-1:0]  addr_q;
  logic [AW-1:0]  paddr_q;
  logic           done_q;
  logic           fault_q;

  logic [HI_W-1:0]  hi_idx;
  logic [MID_W-1:0] mid_idx;
  logic [AW-1:0]    ent_base;
  logic             ent_ok;

  assign hi_idx   = vaddr_i[AW-1 -: HI_W];
  assign mid_idx  = va_q[OFS_W +: MID_W];
  assign ent_base = {mem_rdata_i[AW-1:OFS_W], {OFS_W{1'b0}}};
  assign ent_ok   = mem_rdata_i[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      paddr_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            va_q    <= vaddr_i;
            addr_q  <= root_base_i + (AW'(hi_idx) << ENT_SH);
            state_q <= ST_TOP;
          end
        end
        ST_TOP: begin
          if (mem_rvalid_i) begin
            if (ent_ok) begin
              addr_q  <= ent_base + (AW'(mid_idx) << ENT_SH);
              state_q <= ST_LEAF;
            end else begin
              paddr_q <= '0;
              fault_q <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_LEAF: begin
          if (mem_rvalid_i) begin
            paddr_q <= ent_ok ? {mem_rdata_i[AW-1:OFS_W], va_q[OFS_W-1:0]} : '0;
            fault_q <= !ent_ok;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q != ST_IDLE);
  assign mem_addr_o = addr_q;
  assign paddr_o    = paddr_q;
  assign done_o     = done_q;
  assign fault_o    = fault_q;

endmodule

module pt_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [AW-1:0] paddr_o,
  input logic          done_o,
  input logic          fault_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i,
  input logic [AW-1:0] mem_rdata_i
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !mem_req_o |=> mem_req_o);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  // R5
  absent_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_rvalid_i && !mem_rdata_i[0] |=> done_o && fault_o && !mem_req_o);

  // R4
  done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(paddr_o) && $stable(fault_o));

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> paddr_o == '0);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req_o && !start_i |=> !mem_req_o && !done_o);

endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) u_pt_walker_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .paddr_o(paddr_o),
  .done_o(done_o), .fault_o(fault_o), .mem_req_o(mem_req_o),
  .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ROOT  = 32'h0010_0000;
  localparam logic [31:0] LEAF0 = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] vaddr_i;
  logic [31:0] root_base_i;
  logic [31:0] paddr_o;
  logic        done_o;
  logic        fault_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
    .root_base_i(root_base_i), .paddr_o(paddr_o), .done_o(done_o),
    .fault_o(fault_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] top_word(input int i);
    logic [31:0] w;
    w = LEAF0 + (32'(i) << 12) | (32'(i & 511) << 1);
    w[0] = (i % 7) != 3;
    return w;
  endfunction

  function automatic logic [31:0] leaf_word(input int i, input int j);
    logic [31:0] w;
    w = (32'((i * 37 + j * 11 + 5) & 32'h3F_FFFF) << 10) | (32'((j * 3) & 511) << 1);
    w[0] = ((i + j) % 5) != 0;
    return w;
  endfunction

  logic [31:0] last_pa = '0;
  logic        last_ft = 1'b0;

  task automatic walk(input logic [31:0] va, input int lat, input bit poke);
    int i, j;
    logic [31:0] tw, lw, exp_pa;
    i = int'(va[31:20]);
    j = int'(va[19:10]);
    tw = top_word(i);
    @(negedge clk); start_i = 1'b1; vaddr_i = va;
    @(negedge clk); start_i = 1'b0;
    chk("R2 req", {31'b0, mem_req_o}, 32'd1);
    chk("R2 addr", mem_addr_o, ROOT + 32'(i) * 4);
    for (int c = 0; c < lat; c++) begin
      if (poke) begin start_i = 1'b1; vaddr_i = ~va; end
      @(negedge clk);
      start_i = 1'b0; vaddr_i = 32'h0;
      chk("R7 top addr", mem_addr_o, ROOT + 32'(i) * 4);
    end
    mem_rvalid_i = 1'b1; mem_rdata_i = tw;
    @(negedge clk); mem_rvalid_i = 1'b0; mem_rdata_i = 32'hDEAD_BEEE;
    if (!tw[0]) begin
      chk("R5 done", {31'b0, done_o}, 32'd1);
      chk("R5 fault", {31'b0, fault_o}, 32'd1);
      chk("R5 no second read", {31'b0, mem_req_o}, 32'd0);
      chk("R6 zero pa", paddr_o, 32'd0);
      last_pa = 32'd0; last_ft = 1'b1;
    end else begin
      chk("R3 req", {31'b0, mem_req_o}, 32'd1);
      chk("R3 addr", mem_addr_o, {tw[31:10], 10'b0} + 32'(j) * 4);
      lw = leaf_word(i, j);
      for (int c = 0; c < lat; c++) begin
        if (poke) begin start_i = 1'b1; vaddr_i = va ^ 32'h0005_5400; end
        @(negedge clk);
        start_i = 1'b0; vaddr_i = 32'h0;
        chk("R7 leaf addr", mem_addr_o, {tw[31:10], 10'b0} + 32'(j) * 4);
      end
      mem_rvalid_i = 1'b1; mem_rdata_i = lw;
      @(negedge clk); mem_rvalid_i = 1'b0;
      exp_pa = lw[0] ? {lw[31:10], va[9:0]} : 32'd0;
      chk(lw[0] ? "R4 done" : "R6 done", {31'b0, done_o}, 32'd1);
      chk(lw[0] ? "R4 fault" : "R6 fault", {31'b0, fault_o}, {31'b0, !lw[0]});
      chk(poke ? "R8 pa" : (lw[0] ? "R4 pa" : "R6 pa"), paddr_o, exp_pa);
      chk("R4 req low", {31'b0, mem_req_o}, 32'd0);
      last_pa = exp_pa; last_ft = !lw[0];
    end
    @(negedge clk);
    chk("R9 pulse", {31'b0, done_o}, 32'd0);
    chk("R9 pa hold", paddr_o, last_pa);
    chk("R9 fault hold", {31'b0, fault_o}, {31'b0, last_ft});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; vaddr_i = '0; root_base_i = ROOT;
    mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 req", {31'b0, mem_req_o}, 32'd0);
    chk("R1 done", {31'b0, done_o}, 32'd0);
    chk("R1 fault", {31'b0, fault_o}, 32'd0);
    chk("R1 pa", paddr_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'b0, mem_req_o, done_o, fault_o}, 32'd0);

    walk(32'h0000_0000, 0, 1'b0);
    walk(32'hFFFF_FFFF, 2, 1'b0);
    walk(32'h0010_0400, 1, 1'b1);

    mem_rvalid_i = 1'b1; mem_rdata_i = 32'hFFFF_FFFF;
    @(negedge clk); mem_rvalid_i = 1'b0;
    @(negedge clk);
    chk("R10 req", {31'b0, mem_req_o}, 32'd0);
    chk("R10 done", {31'b0, done_o}, 32'd0);
    chk("R10 pa", paddr_o, last_pa);
    chk("R10 fault", {31'b0, fault_o}, {31'b0, last_ft});

    for (int k = 0; k < 400; k++) begin
      logic [31:0] va;
      va = {12'((k * 331) % 4096), 10'((k * 97) % 1024), 10'((k * 13 + 7) % 1024)};
      walk(va, k % 4, (k % 3 == 1) && (k % 4 != 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule